// File: doc/BRIEF.md
# Zoned Two-Wire Memory Slave

This block is a two-wire serial slave in front of a 1-Kbyte register-file memory that stands in for EEPROM. A bus master opens every transaction with a start condition and then sends a control byte. The control byte carries the slave's 4-bit identity, the upper pointer bits and the transfer direction. Writes name a low address byte and then send one or more data bytes. Reads return bytes from the current pointer, one byte after another, until the master declines to acknowledge.

The array is split into eight zones of 128 bytes. Each zone has its own write-enable bit. A write transaction that a stop closes starts a self-timed busy window. During that window the slave ignores its own identity. The SCL and SDA inputs are sampled by the system clock through two-stage synchronisers. SDA is driven only by pulling it low, through an open-drain enable output.

Top module: `zoned_twowire_mem`

## Requirements
- R1: A command is taken only after a start condition, which is SDA falling while SCL is high. Bits clocked in before any start are not acknowledged.
- R2: The control byte is laid out as bits [7:4] identity, bit 3 zero, bits [2:1] pointer bits 9:8 (used on writes only), and bit 0 direction (1 = read). A byte whose identity differs from `dev_sel` is not acknowledged.
- R3: Each accepted control, address or data byte is acknowledged by pulling SDA low for the whole ninth SCL pulse.
- R4: A single data byte written to an address reads back unchanged.
- R5: During a multi-byte write only pointer bits 3:0 advance, wrapping inside the 16-byte page. Bits 9:4 stay fixed, and bytes outside the page are untouched.
- R6: After a stop that ends a write with at least one data byte, the control byte is not acknowledged for WR_CYCLES clocks. After that window it is acknowledged again.
- R7: A data byte aimed at a zone (pointer bits 9:7) whose `zone_we` bit is 0 is acknowledged, but the memory keeps its old value.
- R8: Reads advance the pointer by one per byte, across page and zone boundaries, and wrap from 1023 to 0.
- R9: When the master does not acknowledge a read byte, the slave stops driving SDA. It responds to nothing until the next start.
- R10: After reset the slave is idle and SDA is not driven.
- R11: The slave changes its SDA drive only while SCL is low, so SDA is stable throughout each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data level seen on the bus |
| dev_sel | input | 4 | Identity this slave answers to |
| zone_we | input | 8 | Write-enable bit per 128-byte zone |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong state-machine or bit-count state shows up within one byte time. The symptom is an acknowledge missing or out of place on the ninth pulse, or a read bit shifted by one position. A pointer fault shows on the next readback, as bytes in the wrong order or a page write that spills past its 16-byte boundary. A busy-window fault shows on the first control byte after a write's stop, because that byte should be refused and is acknowledged instead.

// File: rtl/zoned_twowire_mem.sv
module zoned_twowire_mem #(
  parameter int ADDR_W    = 10,
  parameter int ZONES     = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [3:0]       dev_sel,
  input  logic [ZONES-1:0] zone_we,
  output logic             sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ZW    = $clog2(ZONES);
  localparam int HI    = ADDR_W - 8;
  localparam int BW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDATA, S_READ} st_t;

  logic [7:0]        mem [DEPTH];
  logic [2:0]        scl_p, sda_p;
  st_t               st, nxt;
  logic [3:0]        cnt;
  logic [7:0]        sh, txd;
  logic [ADDR_W-1:0] ptr;
  logic [BW-1:0]     busy_cnt;
  logic              ack, mack, wrote;

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];
  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;
  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_end = fall & ~ack & (cnt == 4'd8);
  wire busy     = busy_cnt != '0;
  wire [ZW-1:0] zone = ptr[ADDR_W-1 -: ZW];
  wire data_go  = (st == S_WDATA) & byte_end;
  wire ctrl_ok  = (sh[7:4] == dev_sel) & ~sh[3] & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk)
    if (rst_n && data_go && zone_we[zone]) mem[ptr] <= sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sh <= '0; txd <= '0;
      ptr <= '0; busy_cnt <= '0; ack <= 1'b0; mack <= 1'b0;
      wrote <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (start) begin
        st <= S_CTRL; cnt <= '0; ack <= 1'b0; sda_oe <= 1'b0; wrote <= 1'b0;
      end else if (stop) begin
        if (st == S_WDATA && wrote) busy_cnt <= BW'(WR_CYCLES);
        st <= S_IDLE; ack <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_CTRL, S_ADDR, S_WDATA: begin
            if (ack) begin
              if (fall) begin
                ack <= 1'b0; cnt <= '0; st <= nxt;
                if (nxt == S_READ) begin
                  txd <= mem[ptr]; sda_oe <= ~mem[ptr][7];
                end else sda_oe <= 1'b0;
              end
            end else if (rise && cnt != 4'd8) begin
              sh <= {sh[6:0], sda_s}; cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              case (st)
                S_CTRL:
                  if (ctrl_ok) begin
                    ack <= 1'b1; sda_oe <= 1'b1;
                    nxt <= sh[0] ? S_READ : S_ADDR;
                    if (!sh[0]) ptr[ADDR_W-1:8] <= sh[HI:1];
                  end else st <= S_IDLE;
                S_ADDR: begin
                  ptr[7:0] <= sh; ack <= 1'b1; sda_oe <= 1'b1; nxt <= S_WDATA;
                end
                default: begin
                  ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                  wrote <= 1'b1; ack <= 1'b1; sda_oe <= 1'b1; nxt <= S_WDATA;
                end
              endcase
            end
          end
          S_READ: begin
            if (fall) begin
              if (cnt < 4'd7) begin
                txd <= txd << 1; sda_oe <= ~txd[6]; cnt <= cnt + 1'b1;
              end else if (cnt == 4'd7) begin
                sda_oe <= 1'b0; cnt <= 4'd8; ptr <= ptr + 1'b1;
              end else if (mack) begin
                txd <= mem[ptr]; sda_oe <= ~mem[ptr][7]; cnt <= '0;
              end else st <= S_IDLE;
            end else if (rise && cnt == 4'd8) mack <= ~sda_s;
          end
          default: ;
        endcase
      end
    end
  end

  assert_foreign_id_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CTRL && byte_end && sh[7:4] != dev_sel) |=> !sda_oe);

  assert_busy_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CTRL && byte_end && busy) |=> !sda_oe);

  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

// File: tb/tb_zoned_twowire_mem.sv
module tb_zoned_twowire_mem;
  localparam int WR = 600;
  localparam int Q  = 6;
  localparam logic [3:0] ID = 4'hA;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic [3:0] dev_sel = ID;
  logic [7:0] zone_we = 8'hFF;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  zoned_twowire_mem #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .dev_sel(dev_sel), .zone_we(zone_we), .sda_oe(sda_oe));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] model [1024];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rx_b;
  int         unstable = 0;
  event       rd_ev;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(rd_ev) begin
    if (exp_q.size() == 0) check(0, "scoreboard-empty", rx_b, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(rx_b === e, t, rx_b, e);
    end
  end

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_start;
    sda_m = 1; wclk(Q); scl = 1; wclk(Q); sda_m = 0; wclk(Q); scl = 0; wclk(2);
  endtask

  task automatic do_stop;
    sda_m = 0; wclk(Q); scl = 1; wclk(Q); sda_m = 1; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(Q); scl = 1; wclk(2*Q); scl = 0; wclk(2);
    end
    sda_m = 1; wclk(Q); scl = 1; wclk(Q); ackd = !sda_bus; wclk(Q); scl = 0; wclk(2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic early;
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      wclk(Q); scl = 1; wclk(1); early = sda_bus; wclk(Q);
      b = {b[6:0], sda_bus}; wclk(Q - 2);
      if (sda_bus !== early) unstable++;
      scl = 0; wclk(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wclk(Q); scl = 1; wclk(2*Q); scl = 0; wclk(2); sda_m = 1;
  endtask

  function automatic logic [7:0] ctrl(input logic [3:0] id, input logic [9:0] a, input bit rd);
    return {id, 1'b0, a[9:8], rd};
  endfunction

  task automatic set_ptr(input logic [9:0] a, input string req);
    bit k;
    do_start; send_byte(ctrl(ID, a, 0), k); check(k, req, k, 1);
    send_byte(a[7:0], k); check(k, req, k, 1); do_stop;
  endtask

  task automatic write_bytes(input logic [9:0] a, input int n, input logic [7:0] base, input string req);
    bit k;
    logic [9:0] p = a;
    do_start; send_byte(ctrl(ID, a, 0), k); check(k, "R3", k, 1);
    send_byte(a[7:0], k); check(k, "R3", k, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), k); check(k, req, k, 1);
      if (zone_we[p[9:7]]) model[p] = base + 8'(i);
      p[3:0] = p[3:0] + 1'b1;
    end
    do_stop; wclk(WR + 50);
  endtask

  task automatic read_seq(input logic [9:0] a, input int n, input bit stop_after, input string req);
    bit k;
    logic [7:0] b;
    logic [9:0] p = a;
    set_ptr(a, req);
    do_start; send_byte(ctrl(ID, 10'd0, 1), k); check(k, req, k, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[p]); tag_q.push_back(req);
      recv_byte(i < n - 1, b); rx_b = b; -> rd_ev; wclk(1);
      p = p + 1'b1;
    end
    if (stop_after) do_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit k;
    logic [7:0] b;
    wclk(5); rst_n = 1; wclk(3);
    check(sda_oe == 0, "R10 idle after reset", sda_oe, 0);

    send_byte(ctrl(ID, 10'd0, 0), k);
    check(!k, "R1 no start no ack", k, 0);
    do_stop;

    do_start; send_byte(ctrl(4'h5, 10'd0, 0), k);
    check(!k, "R2 foreign id", k, 0); do_stop;
    do_start; send_byte(8'hA8, k);
    check(!k, "R2 bit3 set", k, 0); do_stop;

    do_start; send_byte(ctrl(ID, 10'h005, 0), k); check(k, "R3 ctrl", k, 1);
    send_byte(8'h05, k); check(k, "R3 addr", k, 1);
    send_byte(8'h3C, k); check(k, "R4 data ack", k, 1);
    model[10'h005] = 8'h3C;
    do_stop;
    do_start; send_byte(ctrl(ID, 10'd0, 0), k);
    check(!k, "R6 busy nack", k, 0); do_stop;
    wclk(WR);
    do_start; send_byte(ctrl(ID, 10'd0, 0), k);
    check(k, "R6 ack after busy", k, 1); do_stop;
    read_seq(10'h005, 1, 1, "R4");

    write_bytes(10'h130, 16, 8'h40, "R5");
    write_bytes(10'h140, 1, 8'h99, "R5");
    write_bytes(10'h13C, 6, 8'h80, "R5");
    read_seq(10'h130, 17, 1, "R5");

    zone_we[2] = 1'b0;
    write_bytes(10'h135, 1, 8'hEE, "R7");
    zone_we[2] = 1'b1;
    read_seq(10'h135, 1, 1, "R7");

    write_bytes(10'h3FF, 1, 8'h11, "R8");
    write_bytes(10'h000, 1, 8'h22, "R8");
    read_seq(10'h3FF, 2, 1, "R8");
    read_seq(10'h07E, 1, 1, "R8");

    read_seq(10'h005, 1, 0, "R9");
    send_byte(ctrl(ID, 10'd0, 0), k);
    check(!k, "R9 standby after nack", k, 0);
    check(sda_oe == 0, "R9 released", sda_oe, 0);
    do_stop;

    check(unstable == 0, "R11 sda stable while scl high", unstable, 0);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule